// File: doc/BRIEF.md
# Masked Alarm Match Comparator

This block decides when a calendar alarm fires. Once per second, on a one-cycle tick, it compares the running BCD clock fields with a set of alarm bytes. The fields are seconds, minutes, hours, date and month. Every alarm byte carries its own compare-enable in bit 7. Only enabled fields take part in the match, so an alarm can ignore any mix of fields. For example, it can fire every hour at a given minute and second, or every day at a given time.

A match on a tick sets a sticky pending flag. The flag stays set until software pulses a clear strobe. The interrupt output is the pending flag gated by a global alarm enable. Timekeeping and the storage of the alarm and clock registers live outside this block; it sees their contents as plain inputs. All pins are plain control or status levels and strobes. No streamed data crosses the boundary, so there is no valid/ready handshake and no back-pressure.

Top module: `alarm_match_top`

## Requirements
- R1: After reset, pending_o and irq_o are 0.
- R2: When tick_i is high in a cycle and every enabled field matches, pending_o is 1 from the next cycle on. Field i of time_i and alarm_i sits in bits [8i+7:8i], in the order seconds, minutes, hours, date, month.
- R3: A field whose alarm byte has bit 7 clear counts as matching, whatever the clock and alarm values hold.
- R4: If any field whose alarm bit 7 is set differs in its compared bits, a tick does not set pending_o.
- R5: If no alarm byte has bit 7 set, a tick never sets pending_o.
- R6: Without tick_i, matching fields do not set pending_o.
- R7: For the hours field only bits 5:0 are compared. Bit 7 of the clock hour byte (24-hour mode) and bit 6 have no effect.
- R8: pending_o stays 1 until clr_i is pulsed; it reads 0 in the cycle after the clear.
- R9: If clr_i and a setting tick occur in the same cycle, pending_o stays 1.
- R10: irq_o is 1 exactly when pending_o is 1 and alarm_en_i is 1. alarm_en_i has no effect on pending_o.
- R11: For fields other than hours, bits 6:0 are compared. Bit 7 of the clock byte has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle once-per-second evaluate strobe |
| clr_i | input | 1 | Clears the pending flag |
| alarm_en_i | input | 1 | Global alarm interrupt enable |
| time_i | input | NUM_FIELDS*8 | Current BCD clock bytes, one per field |
| alarm_i | input | NUM_FIELDS*8 | Alarm bytes, bit 7 = field compare-enable |
| pending_o | output | 1 | Sticky alarm pending flag |
| irq_o | output | 1 | Interrupt, pending gated by global enable |

## Verification
The bench builds the block with its defaults: five fields with hours at index 2, so the weekday mask variant stays unused. With these values the bench can reach every mix of field enables among the five fields. It also reaches the hour-only mask that hides the 24-hour mode bit and the 7-bit mask on the other fields. Directed scenarios cover a single masked field, a single mismatched field, an all-disabled alarm, a clear that collides with a setting tick, and the global enable changing while the flag is held.

// File: rtl/alarm_cmp_pkg.sv
package alarm_cmp_pkg;
  localparam int BYTE_W = 8;
  localparam int EN_BIT = 7;

  // Value bits compared for a field: hours keep 5:0, weekday 2:0, others 6:0
  function automatic logic [6:0] field_mask(int idx, int hour_idx, int wday_idx);
    if (idx == hour_idx)      return 7'h3F;
    else if (idx == wday_idx) return 7'h07;
    else                      return 7'h7F;
  endfunction
endpackage

// File: rtl/alarm_field_cmp.sv
module alarm_field_cmp
  import alarm_cmp_pkg::*;
#(
  parameter logic [6:0] VAL_MASK = 7'h7F
) (
  input  logic [BYTE_W-1:0] cur_i,
  input  logic [BYTE_W-1:0] alm_i,
  output logic              en_o,
  output logic              hit_o
);
  logic [6:0] cur_v, alm_v;

  always_comb begin
    cur_v = cur_i[6:0] & VAL_MASK;
    alm_v = alm_i[6:0] & VAL_MASK;
    en_o  = alm_i[EN_BIT];
    hit_o = !en_o || (cur_v == alm_v);
  end
endmodule

// File: rtl/alarm_match_reduce.sv
module alarm_match_reduce #(
  parameter int N = 5
) (
  input  logic [N-1:0] en_i,
  input  logic [N-1:0] hit_i,
  output logic         fire_o
);
  always_comb fire_o = (|en_i) && (&hit_i);
endmodule

// File: rtl/alarm_pending_reg.sv
module alarm_pending_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic fire_i,
  input  logic clr_i,
  output logic pending_o
);
  logic set_now;
  always_comb set_now = tick_i && fire_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pending_o <= 1'b0;
    else if (set_now) pending_o <= 1'b1;
    else if (clr_i)   pending_o <= 1'b0;
  end
endmodule

// File: rtl/alarm_match_top.sv
module alarm_match_top
  import alarm_cmp_pkg::*;
#(
  parameter int NUM_FIELDS = 5,
  parameter int HOUR_IDX   = 2,
  parameter int WDAY_IDX   = 6
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         tick_i,
  input  logic                         clr_i,
  input  logic                         alarm_en_i,
  input  logic [NUM_FIELDS*BYTE_W-1:0] time_i,
  input  logic [NUM_FIELDS*BYTE_W-1:0] alarm_i,
  output logic                         pending_o,
  output logic                         irq_o
);
  localparam int VEC_W = NUM_FIELDS * BYTE_W;

  logic [NUM_FIELDS-1:0] en_vec;
  logic [NUM_FIELDS-1:0] hit_vec;
  logic                  fire;

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
    alarm_field_cmp #(
      .VAL_MASK(field_mask(g, HOUR_IDX, WDAY_IDX))
    ) u_cmp (
      .cur_i(time_i[g*BYTE_W +: BYTE_W]),
      .alm_i(alarm_i[g*BYTE_W +: BYTE_W]),
      .en_o (en_vec[g]),
      .hit_o(hit_vec[g])
    );
  end

  alarm_match_reduce #(.N(NUM_FIELDS)) u_reduce (
    .en_i  (en_vec),
    .hit_i (hit_vec),
    .fire_o(fire)
  );

  alarm_pending_reg u_flag (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_i   (tick_i),
    .fire_i   (fire),
    .clr_i    (clr_i),
    .pending_o(pending_o)
  );

  always_comb irq_o = pending_o && alarm_en_i;

  logic unused_w;
  always_comb unused_w = ^VEC_W;
endmodule

// File: rtl/alarm_match_chk.sv
module alarm_match_chk #(
  parameter int NUM_FIELDS = 5
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     tick_i,
  input logic                     clr_i,
  input logic                     alarm_en_i,
  input logic [NUM_FIELDS*8-1:0]  alarm_i,
  input logic                     pending_o,
  input logic                     irq_o
);
  logic any_en;
  always_comb begin
    any_en = 1'b0;
    for (int i = 0; i < NUM_FIELDS; i++) any_en = any_en | alarm_i[i*8+7];
  end

  // R6
  set_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pending_o) |-> $past(tick_i));

  // R5
  no_enable_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !any_en && !pending_o) |=> !pending_o);

  // R8
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pending_o && !clr_i) |=> pending_o);

  // R8
  fall_needs_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pending_o) |-> $past(clr_i));

  // R10
  irq_implies_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (pending_o && alarm_en_i));

  // R10
  irq_when_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pending_o && alarm_en_i) |-> irq_o);
endmodule

bind alarm_match_top alarm_match_chk #(.NUM_FIELDS(NUM_FIELDS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick_i    (tick_i),
  .clr_i     (clr_i),
  .alarm_en_i(alarm_en_i),
  .alarm_i   (alarm_i),
  .pending_o (pending_o),
  .irq_o     (irq_o)
);

// File: tb/tb_alarm_match_top.sv
module tb_alarm_match_top;
  localparam int NF = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_i = 1'b0, clr_i = 1'b0, alarm_en_i = 1'b0;
  logic [NF*8-1:0] time_i = '0, alarm_i = '0;
  logic pending_o, irq_o;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  alarm_match_top dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .clr_i(clr_i),
    .alarm_en_i(alarm_en_i), .time_i(time_i), .alarm_i(alarm_i),
    .pending_o(pending_o), .irq_o(irq_o)
  );

  // Base clock: 13:30:45 in 24h mode, date 21, month 06
  localparam logic [NF*8-1:0] TBASE = {8'h06, 8'h21, 8'h93, 8'h30, 8'h45};
  // Alarm equal to TBASE with all five enables set
  localparam logic [NF*8-1:0] AFULL = {8'h86, 8'hA1, 8'h93, 8'hB0, 8'hC5};

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic do_tick(logic with_clr);
    @(negedge clk);
    tick_i = 1'b1; clr_i = with_clr;
    @(negedge clk);
    tick_i = 1'b0; clr_i = 1'b0;
  endtask

  task automatic do_clear();
    @(negedge clk); clr_i = 1'b1;
    @(negedge clk); clr_i = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 pending", pending_o, 1'b0);
    check("R1 irq", irq_o, 1'b0);
  endtask

  task automatic t_full_match();
    time_i = TBASE; alarm_i = AFULL; alarm_en_i = 1'b1;
    do_tick(1'b0);
    check("R2 full match", pending_o, 1'b1);
    check("R10 irq enabled", irq_o, 1'b1);
    do_clear();
    check("R8 cleared", pending_o, 1'b0);
  endtask

  task automatic t_masked_field();
    time_i = TBASE; alarm_i = AFULL;
    alarm_i[15:8] = 8'h12;          // minutes disabled, value differs
    do_tick(1'b0);
    check("R3 masked minute", pending_o, 1'b1);
    do_clear();
    alarm_i = {8'h00, 8'h00, 8'h00, 8'h00, 8'hC5}; // seconds only
    time_i[39:8] = 32'h0;
    do_tick(1'b0);
    check("R3 seconds only", pending_o, 1'b1);
    do_clear();
  endtask

  task automatic t_mismatch();
    time_i = TBASE; alarm_i = AFULL;
    alarm_i[31:24] = 8'hA2;         // date 22 vs 21
    do_tick(1'b0);
    check("R4 date mismatch", pending_o, 1'b0);
    alarm_i = AFULL; alarm_i[7:0] = 8'hC6;
    do_tick(1'b0);
    check("R4 seconds mismatch", pending_o, 1'b0);
  endtask

  task automatic t_no_enables();
    time_i = TBASE;
    alarm_i = {8'h06, 8'h21, 8'h13, 8'h30, 8'h45};
    do_tick(1'b0);
    check("R5 no enables", pending_o, 1'b0);
    check("R5 irq", irq_o, 1'b0);
  endtask

  task automatic t_no_tick();
    time_i = TBASE; alarm_i = AFULL;
    repeat (4) @(negedge clk);
    check("R6 no tick", pending_o, 1'b0);
  endtask

  task automatic t_hour_bits();
    time_i = TBASE; alarm_i = AFULL;
    time_i[23:16] = 8'h53;          // bit7 clear, bit6 set, hour 13
    alarm_i[23:16] = 8'hD3;         // enable, bit6 set, hour 13
    do_tick(1'b0);
    check("R7 hour upper bits ignored", pending_o, 1'b1);
    do_clear();
    time_i[23:16] = 8'h94;          // hour 14
    alarm_i[23:16] = 8'h93;
    do_tick(1'b0);
    check("R7 hour differs", pending_o, 1'b0);
  endtask

  task automatic t_sticky();
    time_i = TBASE; alarm_i = AFULL;
    do_tick(1'b0);
    time_i[7:0] = 8'h46;            // time moves on
    repeat (5) @(negedge clk);
    check("R8 sticky", pending_o, 1'b1);
    do_tick(1'b0);
    check("R8 sticky after non-match tick", pending_o, 1'b1);
    do_clear();
    check("R8 clear", pending_o, 1'b0);
  endtask

  task automatic t_same_tick();
    time_i = TBASE; alarm_i = AFULL;
    do_tick(1'b1);
    check("R9 set wins from clear", pending_o, 1'b1);
    do_tick(1'b1);
    check("R9 set wins while held", pending_o, 1'b1);
    do_clear();
  endtask

  task automatic t_global_en();
    time_i = TBASE; alarm_i = AFULL; alarm_en_i = 1'b0;
    do_tick(1'b0);
    check("R10 pending without enable", pending_o, 1'b1);
    check("R10 irq gated", irq_o, 1'b0);
    @(negedge clk); alarm_en_i = 1'b1;
    #1 check("R10 irq follows enable", irq_o, 1'b1);
    @(negedge clk); alarm_en_i = 1'b0;
    #1 check("R10 irq drops", irq_o, 1'b0);
    check("R10 pending kept", pending_o, 1'b1);
    do_clear();
  endtask

  task automatic t_bit7();
    time_i = TBASE; alarm_i = AFULL;
    time_i[7:0] = 8'hC5; time_i[39:32] = 8'h86;
    do_tick(1'b0);
    check("R11 clock bit7 ignored", pending_o, 1'b1);
    do_clear();
    time_i = TBASE; time_i[15:8] = 8'h70;  // minute 70 vs 30 in bit 6
    do_tick(1'b0);
    check("R11 bit6 compared", pending_o, 1'b0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_full_match();
        t_masked_field();
        t_mismatch();
        t_no_enables();
        t_no_tick();
        t_hour_bits();
        t_sticky();
        t_same_tick();
        t_global_en();
        t_bit7();
      end
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule